// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters written by a host into an asynchronous NRZ serial stream. A host write drops one character into a holding buffer. A transmit shift register takes characters from that buffer and frames each one as a low start bit, then the data bits least-significant first, then a high stop bit. A character is 8 bits wide, or 9 bits when nine-bit mode is selected.

Because of the double buffering, the host can queue the next character while the current one is still on the wire. The shift register reloads in the same clock edge at which the previous stop bit ends, so consecutive characters leave with no idle time between them. Bit timing comes from an external bit-rate tick. Each bit lasts a fixed number of those ticks. A buffer-empty flag, gated by an interrupt enable, tells the host when it may write again.

The shift engine is a four-state machine. `ST_IDLE` moves to `ST_START` when a transfer happens. `ST_START` moves to `ST_DATA` when its bit time ends. `ST_DATA` stays in place, shifting, until the last data bit ends, and then moves to `ST_STOP`. `ST_STOP` moves back to `ST_START` at the end of the stop bit if the buffer holds a character, and to `ST_IDLE` if it does not.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset, and whenever no character is in progress, `tx_line` is 1, and both `buf_empty` and `tsr_empty` are 1.
- R2: Each frame on `tx_line` is one start bit of value 0, then the data bits with bit 0 first, then one stop bit of value 1.
- R3: When `mode9` is 1 at the moment of transfer, the frame carries 9 data bits, and `wr_bit9` is sent after bit 7. When `mode9` is 0, only 8 data bits are sent.
- R4: Every start, data and stop bit stays on the line for exactly `TICKS_PER_BIT` pulses of `bit_tick`. The start bit ends on the `TICKS_PER_BIT`-th tick after the transfer.
- R5: A write (`wr_en` high) to an empty buffer makes `buf_empty` 0 one cycle later. If the shift engine is idle, the transfer takes place on the following clock edge.
- R6: A transfer takes one clock edge. After it, `tx_line` is 0 (start bit), `tsr_empty` is 0 and `buf_empty` is 1.
- R7: A write while the buffer is full is ignored. The character already held is the one transmitted, and no extra frame follows.
- R8: The shift register does not reload until the current stop bit has ended. A character queued during a frame starts in the cycle right after that stop bit, with no idle bit time in between.
- R9: `irq` is 1 exactly when `buf_empty` is 1 and `irq_en` is 1.
- R10: `tsr_empty` returns to 1 in the cycle after the last stop bit when no character is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe into the holding buffer |
| wr_data | input | DATA_W | Low data bits of the character |
| wr_bit9 | input | 1 | Ninth data bit, used in nine-bit mode |
| mode9 | input | 1 | Selects 9 data bits per frame |
| irq_en | input | 1 | Enables the buffer-empty interrupt |
| bit_tick | input | 1 | Bit-rate tick, one clock wide |
| tx_line | output | 1 | Serial output, idles at 1 |
| buf_empty | output | 1 | Holding buffer is empty |
| irq | output | 1 | Buffer-empty interrupt request |
| tsr_empty | output | 1 | Shift register idle |

## Verification
The bench builds the block with `DATA_W` = 8 and `TICKS_PER_BIT` = 2, and it pulses `bit_tick` once every three clocks. These values keep a frame short enough that several framing, queueing and interrupt scenarios fit in one run. They also keep the tick counter on its multi-tick path, so that a bit which is one tick too long or too short shows up as a mismatch among the samples of that bit. The slow tick, compared with a write, lets a second and a third write land inside the first frame. This covers the held-while-full and the gap-free reload cases.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } txst_e;

endpackage

// File: rtl/stx_hold_buf.sv
module stx_hold_buf #(
    parameter int DATA_W = 8,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            word <= wr_word;
        end
    end

    // A write into a full buffer must leave the held word untouched
    assert_full_write_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !take) |=> (full && word == $past(word)));

endmodule

// File: rtl/stx_bit_timer.sv
module stx_bit_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic bit_done
);

    generate
        if (TICKS_PER_BIT == 1) begin : g_direct
            assign bit_done = run && tick;
        end else begin : g_count
            localparam int CNT_W = $clog2(TICKS_PER_BIT);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);
            logic [CNT_W-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (restart) begin
                    cnt <= '0;
                end else if (run && tick) begin
                    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                end
            end

            assign bit_done = run && tick && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/stx_shift_fsm.sv
module stx_shift_fsm
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WORD_W = DATA_W + 1,
    localparam int IDX_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [WORD_W-1:0] load_word,
    input  logic              load_nine,
    input  logic              bit_done,
    output logic              tx_line,
    output logic              busy,
    output logic              stop_done
);

    txst_e             state, state_nx;
    logic [WORD_W-1:0] shreg;
    logic [IDX_W-1:0]  idx, last_idx;

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            idx      <= '0;
            last_idx <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                shreg    <= load_word;
                idx      <= '0;
                last_idx <= load_nine ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
            end else if (state == ST_DATA && bit_done) begin
                shreg <= shreg >> 1;
                idx   <= idx + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (take) state_nx = ST_START;
            ST_START: if (bit_done) state_nx = ST_DATA;
            ST_DATA:  if (bit_done && idx == last_idx) state_nx = ST_STOP;
            ST_STOP:  if (bit_done) state_nx = take ? ST_START : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        stop_done = (state == ST_STOP) && bit_done;
        unique case (state)
            ST_START: tx_line = 1'b0;
            ST_DATA:  tx_line = shreg[0];
            default:  tx_line = 1'b1;
        endcase
    end

    // Data bits are entered only from the start bit
    assert_data_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) != ST_DATA) |-> ($past(state) == ST_START));

endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              mode9,
    input  logic              irq_en,
    input  logic              bit_tick,
    output logic              tx_line,
    output logic              buf_empty,
    output logic              irq,
    output logic              tsr_empty
);

    localparam int WORD_W = DATA_W + 1;

    logic              full, take, busy, stop_done, bit_done;
    logic [WORD_W-1:0] held;

    stx_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word ({wr_bit9, wr_data}),
        .take    (take),
        .full    (full),
        .word    (held)
    );

    stx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .restart  (take),
        .tick     (bit_tick),
        .bit_done (bit_done)
    );

    stx_shift_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .load_word (held),
        .load_nine (mode9),
        .bit_done  (bit_done),
        .tx_line   (tx_line),
        .busy      (busy),
        .stop_done (stop_done)
    );

    // Reload only from idle or at the very end of a stop bit
    assign take      = full && (!busy || stop_done);
    assign buf_empty = !full;
    assign tsr_empty = !busy;
    assign irq       = buf_empty && irq_en;

    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tsr_empty |-> tx_line);

    assert_empty_clears_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> $past(wr_en));

    assert_start_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!tx_line && !tsr_empty && buf_empty));

    assert_reload_at_stop_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (tsr_empty || stop_done));

endmodule

// File: tb/serial_tx_dbuf_test.sv
module serial_tx_dbuf_test;

    localparam int DW   = 8;
    localparam int TPB  = 2;
    localparam int TDIV = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_bit9 = 1'b0;
    logic          mode9 = 1'b0;
    logic          irq_en = 1'b0;
    logic          bit_tick = 1'b0;
    logic          tx_line, buf_empty, irq, tsr_empty;

    int checks = 0;
    int errors = 0;
    int tcnt   = 0;

    serial_tx_dbuf #(.DATA_W(DW), .TICKS_PER_BIT(TPB)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_bit9(wr_bit9), .mode9(mode9), .irq_en(irq_en), .bit_tick(bit_tick),
        .tx_line(tx_line), .buf_empty(buf_empty), .irq(irq), .tsr_empty(tsr_empty)
    );

    always #2 clk = ~clk;

    // Tick source: updated just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tcnt     = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
            bit_tick = (tcnt == 0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [DW-1:0] d, input logic b9);
        @(negedge clk);
        wr_data = d;
        wr_bit9 = b9;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic next_tick(output logic v);
        do @(negedge clk); while (!bit_tick);
        v = tx_line;
    endtask

    // Collects one frame from the line by sampling it at each tick
    task automatic get_frame(input bit imm, input int nb, output logic [8:0] d);
        logic v, w;
        d = '0;
        if (imm) begin
            next_tick(v);
            chk("R8 gap-free next start", int'(v), 0);
        end else begin
            do @(negedge clk); while (!(bit_tick && tx_line == 1'b0));
        end
        for (int i = 1; i < TPB; i++) begin
            next_tick(v);
            chk("R4 start bit length", int'(v), 0);
        end
        for (int b = 0; b < nb; b++) begin
            next_tick(v);
            d[b] = v;
            for (int k = 1; k < TPB; k++) begin
                next_tick(w);
                chk("R4 data bit held", int'(w), int'(v));
            end
        end
        for (int i = 0; i < TPB; i++) begin
            next_tick(v);
            chk("R2 stop bit", int'(v), 1);
        end
    endtask

    task automatic t_reset;
        chk("R1 reset line", int'(tx_line), 1);
        chk("R1 reset buf_empty", int'(buf_empty), 1);
        chk("R1 reset tsr_empty", int'(tsr_empty), 1);
        chk("R9 irq masked", int'(irq), 0);
    endtask

    task automatic t_single;
        logic [8:0] d;
        mode9 = 1'b0;
        do_write(8'hA5, 1'b0);
        chk("R5 buf_empty after write", int'(buf_empty), 0);
        chk("R5 still idle line", int'(tx_line), 1);
        chk("R5 still idle tsr", int'(tsr_empty), 1);
        @(negedge clk);
        chk("R6 start bit after transfer", int'(tx_line), 0);
        chk("R6 buf_empty after transfer", int'(buf_empty), 1);
        chk("R6 tsr busy", int'(tsr_empty), 0);
        get_frame(1'b0, 8, d);
        chk("R2 data lsb first", int'(d), 9'h0A5);
        @(negedge clk);
        chk("R10 tsr_empty after stop", int'(tsr_empty), 1);
        chk("R1 line idle after frame", int'(tx_line), 1);
    endtask

    task automatic t_nine;
        logic [8:0] d;
        mode9 = 1'b1;
        do_write(8'hFF, 1'b0);
        get_frame(1'b0, 9, d);
        chk("R3 ninth bit zero", int'(d), 9'h0FF);
        do_write(8'h3C, 1'b1);
        get_frame(1'b0, 9, d);
        chk("R3 ninth bit one", int'(d), 9'h13C);
        mode9 = 1'b0;
        do_write(8'h81, 1'b0);
        get_frame(1'b0, 8, d);
        chk("R3 eight-bit mode", int'(d), 9'h081);
    endtask

    task automatic t_back_to_back;
        logic [8:0] da, db;
        logic v;
        mode9 = 1'b0;
        do_write(8'h96, 1'b0);
        fork
            get_frame(1'b0, 8, da);
            begin
                do_write(8'h4B, 1'b0);
                chk("R5 second char queued", int'(buf_empty), 0);
                do_write(8'hE7, 1'b0);
                chk("R8 held during frame", int'(buf_empty), 0);
            end
        join
        chk("R2 first char", int'(da), 9'h096);
        get_frame(1'b1, 8, db);
        chk("R7 held char kept", int'(db), 9'h04B);
        next_tick(v);
        chk("R7 no extra frame", int'(v), 1);
        chk("R10 idle after pair", int'(tsr_empty), 1);
        chk("R1 buffer empty after pair", int'(buf_empty), 1);
    endtask

    task automatic t_irq;
        logic [8:0] d;
        irq_en = 1'b1;
        @(negedge clk);
        chk("R9 irq when empty", int'(irq), 1);
        do_write(8'h5A, 1'b0);
        chk("R9 irq drops when full", int'(irq), 0);
        @(negedge clk);
        chk("R9 irq after transfer", int'(irq), 1);
        get_frame(1'b0, 8, d);
        chk("R2 irq frame data", int'(d), 9'h05A);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R9 irq disabled", int'(irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_nine();
        t_back_to_back();
        t_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule